// File: doc/BRIEF.md
# Dual-Channel Boxcar Decimator with Offset-Binary Result

This block turns a pair of 1-bit delta-sigma bitstreams into one 16-bit conversion code. One stream belongs to the positive analog input and the other to the negative input. On a start pulse both channels clear their ones-counters. They then count ones over a fixed window of `2**WIN_LOG2` clock cycles, which forms a first-order sinc (boxcar) filter. The window length sets the first filter notch at the output rate. Every conversion stands alone: nothing carries over from the previous window, so the result has no latency and each start gives exactly one result.

At the end of the window the negative count is subtracted from the positive count. The difference is scaled by a left shift so that a full-window difference equals half the code range. The offset-calibration word latched at start is then subtracted, mid-scale (32768) is added, and the value is clamped into 0..65535. The code register updates together with a one-clock done pulse and holds its value until the next done pulse.

Top module: `dsm_pair_decim`

## Requirements
- R1: While `rst_n` is low, and after reset until the first done pulse, `code_o` reads 0 and `done_o` reads 0.
- R2: A start seen while idle opens a window of N = 2**WIN_LOG2 samples, taken at the N rising edges after the start edge. `done_o` is high for exactly the one clock that follows the N-th sampling edge.
- R3: Each channel counts the ones among its own N samples. Both counts are cleared at start, so a result depends only on its own window.
- R4: The code equals 32768 + (ones_pos − ones_neg)·2**(15−WIN_LOG2) − cal, where cal is the two's-complement offset word, before clamping.
- R5: A value of 65536 or more is delivered as 65535.
- R6: A negative value is delivered as 0.
- R7: Bit 15 of the code is 1 exactly when the value in R4 is at least 32768. Equal counts with cal = 0 give 32768, and equal counts with cal = 1 give 32767.
- R8: `cal_i` is latched on the accepted start edge. Changes to it during the window do not alter that result.
- R9: A start pulse while a window is running is ignored. It neither restarts the count nor produces an extra done pulse.
- R10: `code_o` changes only on the edge that raises `done_o`, and it stays stable between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bitstreams are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a conversion window |
| cal_i | input | 16 | Signed offset-calibration word in output LSBs |
| bit_pos_i | input | 1 | Modulator bitstream of the positive input |
| bit_neg_i | input | 1 | Modulator bitstream of the negative input |
| code_o | output | 16 | Offset-binary conversion result |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives each stream with an exact count of ones per window and targets the edges of the transfer function. These are full positive and full negative difference, a calibration word that pushes the value one step past either end, the zero-difference point with and without a one-LSB offset, and an interior point. A window off by one sample, or accumulators that are not cleared, would shift every interior code by a multiple of the shift step. A clamp wired to the wrong bound would wrap 65536 to 0 or −1 to 65535. A start pulse in mid-window and a calibration change in mid-window are applied as well. A design that restarts on the second start would deliver its done pulse late with a short count. A design that does not latch the offset would produce a code shifted by the new word.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int CODE_W   = 16;
  localparam int CODE_MID = 32768;
  localparam int CODE_TOP = 65535;

  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // unclamped value: mid-scale + scaled difference - calibration
  function automatic int signed raw_value(input int signed diff,
                                          input int          shamt,
                                          input int signed   cal);
    return CODE_MID + (diff <<< shamt) - cal;
  endfunction

  function automatic code_t saturate(input int signed v);
    if (v < 0)             return '0;
    else if (v > CODE_TOP) return '1;
    else                   return code_t'(v);
  endfunction
endpackage

// File: rtl/dsm_win_seq.sv
module dsm_win_seq
  import dsm_pkg::*;
#(
  parameter int WIN_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic sample_o,
  output logic last_o
);
  localparam logic [WIN_LOG2-1:0] IDX_LAST = '1;

  seq_state_e          state_q;
  logic [WIN_LOG2-1:0] idx_q;

  assign accept_o = (state_q == SEQ_IDLE) && start_i;
  assign sample_o = (state_q == SEQ_RUN);
  assign last_o   = sample_o && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else if (accept_o) begin
      state_q <= SEQ_RUN;
      idx_q   <= '0;
    end else if (sample_o) begin
      idx_q <= idx_q + 1'b1;
      if (last_o) state_q <= SEQ_IDLE;
    end
  end

  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !sample_o);                                    // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (sample_o && idx_q == '0));                  // R2
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !last_o) |=> (sample_o && idx_q == $past(idx_q) + 1'b1)); // R9
endmodule

// File: rtl/dsm_ones_acc.sv
module dsm_ones_acc #(
  parameter int CNT_W   = 9,
  parameter int MAX_CNT = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o
);
  assign count_next_o = count_o + CNT_W'(sample_i && bit_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) count_o <= '0;
    else if (sample_i)     count_o <= count_next_o;
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(MAX_CNT));                              // R3
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));                             // R3
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !clear_i) |=> $stable(count_o));            // R3
endmodule

// File: rtl/dsm_code_fmt.sv
module dsm_code_fmt
  import dsm_pkg::*;
#(
  parameter int WIN_LOG2 = 8,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [15:0]      cal_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_pos_i,
  input  logic [CNT_W-1:0] cnt_neg_i,
  output logic [15:0]      cal_held_o,
  output code_t            code_o,
  output logic             done_o
);
  localparam int SHAMT = 15 - WIN_LOG2;

  int signed diff_s;
  int signed value_s;

  always_comb begin
    diff_s  = int'(cnt_pos_i) - int'(cnt_neg_i);
    value_s = raw_value(diff_s, SHAMT, int'($signed(cal_held_o)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cal_held_o <= '0;
    else if (capture_i) cal_held_o <= cal_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) code_o <= saturate(value_s);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                      // R10
  AST_CAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(cal_held_o));                      // R8
endmodule

// File: rtl/dsm_pair_decim.sv
module dsm_pair_decim
  import dsm_pkg::*;
#(
  parameter int WIN_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] cal_i,
  input  logic        bit_pos_i,
  input  logic        bit_neg_i,
  output logic [15:0] code_o,
  output logic        done_o
);
  localparam int WIN_LEN = 1 << WIN_LOG2;
  localparam int CNT_W   = WIN_LOG2 + 1;
  localparam int N_CH    = 2;

  logic             accept_w;
  logic             sample_w;
  logic             last_w;
  logic [N_CH-1:0]  bit_w;
  logic [CNT_W-1:0] cnt_q   [N_CH];
  logic [CNT_W-1:0] cnt_nxt [N_CH];
  logic [15:0]      cal_held_w;

  assign bit_w = {bit_neg_i, bit_pos_i};

  dsm_win_seq #(.WIN_LOG2(WIN_LOG2)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept_w),
    .sample_o (sample_w),
    .last_o   (last_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dsm_ones_acc #(.CNT_W(CNT_W), .MAX_CNT(WIN_LEN)) u_acc (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (accept_w),
      .sample_i     (sample_w),
      .bit_i        (bit_w[c]),
      .count_o      (cnt_q[c]),
      .count_next_o (cnt_nxt[c])
    );
  end

  dsm_code_fmt #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (accept_w),
    .cal_i      (cal_i),
    .load_i     (last_w),
    .cnt_pos_i  (cnt_nxt[0]),
    .cnt_neg_i  (cnt_nxt[1]),
    .cal_held_o (cal_held_w),
    .code_o     (code_o),
    .done_o     (done_o)
  );

  // cross-check of the finished counts against the delivered code
  int signed chk_rel;
  always_comb
    chk_rel = ((int'(cnt_q[0]) - int'(cnt_q[1])) * (1 << (15 - WIN_LOG2)))
              - int'($signed(cal_held_w));

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(sample_w));                              // R2
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));                             // R10
  AST_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (code_o[15] == (chk_rel >= 0)));               // R7
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && chk_rel >= 32768) |-> (code_o == 16'hFFFF));   // R5
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && chk_rel < -32768) |-> (code_o == 16'h0000));   // R6
endmodule

// File: tb/dsm_pair_decim_bench.sv
module dsm_pair_decim_bench;
  localparam int CLK_T = 10;
  localparam int L2    = 6;
  localparam int N     = 1 << L2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] cal_i = '0;
  logic        bit_pos_i = 1'b0;
  logic        bit_neg_i = 1'b0;
  logic [15:0] code_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;
  int exp_q[$];
  string tag_q[$];
  logic [15:0] last_code = '0;
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;

  dsm_pair_decim #(.WIN_LOG2(L2)) u_dsm_pair_decim (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_i(cal_i),
    .bit_pos_i(bit_pos_i), .bit_neg_i(bit_neg_i),
    .code_o(code_o), .done_o(done_o)
  );

  function automatic int expect_code(int kp, int kn, int cal);
    int v;
    v = 32768 + (kp - kn) * (1 << (15 - L2)) - cal;
    if (v > 65535) v = 65535;
    if (v < 0) v = 0;
    return v;
  endfunction

  // exactly k ones spread over N samples
  function automatic logic dens_bit(int k, int j);
    return (((j + 1) * k) / N) != ((j * k) / N);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected done", 1, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(code_o == e[15:0], t, code_o, e);
        end
      end else begin
        check(code_o == last_code, "R10 code held", code_o, last_code);
      end
      last_code = code_o;
    end
  end

  task automatic convert(input int kp, input int kn, input int cal,
                         input bit poke_start, input bit poke_cal, input string tag);
    exp_q.push_back(expect_code(kp, kn, cal));
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b1;
    cal_i   = cal[15:0];
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      start_i   = (poke_start && j == 10);
      if (poke_cal && j == 5) cal_i = 16'd999;
      bit_pos_i = dens_bit(kp, j);
      bit_neg_i = dens_bit(kn, j);
      if (j == N - 1) check(done_o == 1'b0, "R2 no early done", done_o, 0);
    end
    @(negedge clk);
    check(done_o == 1'b1, "R2 done after N samples", done_o, 1);
    bit_pos_i = 1'b0;
    bit_neg_i = 1'b0;
    start_i   = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(code_o == 16'd0, "R1 reset code", code_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(code_o == 16'd0 && done_o == 1'b0, "R1 idle after reset", code_o, 0);

    convert(32, 32, 0,  0, 0, "R7 zero difference mid-scale");
    convert(32, 32, 1,  0, 0, "R7 minus one LSB");
    convert(40, 24, 0,  0, 0, "R4 interior positive");
    convert(10, 50, 100, 0, 0, "R4 interior negative with cal");
    convert(63, 0, 0,   0, 0, "R3 R4 one short of full");
    convert(64, 0, 0,   0, 0, "R5 full positive clamps");
    convert(64, 0, 1,   0, 0, "R5 full minus one exact top");
    convert(64, 0, -3,  0, 0, "R5 beyond top clamps");
    convert(0, 64, 0,   0, 0, "R6 full negative bottom");
    convert(0, 64, 1,   0, 0, "R6 below zero clamps");
    convert(0, 64, -5,  0, 0, "R4 cal lifts off bottom");
    convert(20, 44, 0,  0, 1, "R8 cal change mid-window ignored");
    convert(50, 10, 0,  1, 0, "R9 start mid-window ignored");
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 no pending results", exp_q.size(), 0);
    check(code_o == expect_code(50, 10, 0), "R10 final code held",
          code_o, expect_code(50, 10, 0));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_T * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule